// File: doc/BRIEF.md
# Ethernet MAC Frame Statistics Counters

This block keeps the frame statistics of one Ethernet MAC port, separately for the receive and the transmit side. Event logic elsewhere in the MAC gives it a one-cycle pulse per finished frame, together with the frame length and a set of classification flags. From these the block keeps frame counts, byte totals, per-type counts and a frame-length histogram.

Software reads each statistic through a small synchronous read port. Every counter clears when it is read, so a read returns what has happened since the previous read and software can build wide running totals of its own. The byte totals are wider than one read word. Reading the low word captures the upper bits so that the high-word read that follows belongs to the same snapshot. A separate clear-all input zeroes every statistic at once. Counters stop at their maximum value instead of wrapping around.

Top module: `mstat_top`

## Requirements
- R1: After reset every counter, both upper-bit latches and rd_data are zero.
- R2: A read is a one-cycle rd_en pulse with rd_addr. rd_data shows the selected value one clock later, as it stood before that read, zero-extended to 32 bits, and holds while rd_en is low. Addresses with no register map read as zero.
- R3: A read clears only the addressed counter. An event that arrives in the same cycle as the clearing read is counted into the new period, so the counter holds that event alone afterwards.
- R4: Receive counters: total frames at 0x08; frames with rx_flags bit i set at 0x09+i. The flag bits are 0 multicast, 1 broadcast, 2 CRC error, 3 pause, 4 jabber, 5 short, 6 symbol error and 7 oversize.
- R5: Transmit counters: total frames at 0x18; frames with tx_flags bit i set at 0x19+i. The flag bits are 0 multicast, 1 broadcast, 2 pause and 3 error. Transmit events never change a receive counter.
- R6: Each direction has a length histogram with seven bins: exactly 64 bytes, 65-127, 128-255, 256-511, 512-1023, 1024-1518, and 1519 or more. The receive bins sit at 0x11 to 0x17 and the transmit bins at 0x1D to 0x23, in that bin order. Frames shorter than 64 bytes go into no bin.
- R7: Each direction has a BYTE_W-bit byte total (45 bits by default) that adds the frame length on every event. Its low 32 bits read at 0x00 for receive and 0x02 for transmit.
- R8: A low-word byte read captures bits BYTE_W-1:32 of that total into a latch and clears the whole total. The latch reads at 0x01 for receive and 0x03 for transmit. That read does not change the latch or the total.
- R9: Register 0x04 counts received frames longer than the maximum packet size (rx_toolong), CNT_W-1 bits wide, in its low bits. Bit 31 is the live rx_fifo_empty input as sampled in the read cycle. A read clears the count.
- R10: A stat_clr pulse zeroes every counter and both latches. An event in the same cycle is counted into the new period.
- R11: Frame, type, histogram and too-long counters saturate at all ones, and byte totals saturate at 2^BYTE_W-1. None of them wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_evt | input | 1 | One-cycle pulse per received frame |
| rx_len | input | LEN_W | Received frame length in bytes |
| rx_flags | input | 8 | Receive class flags, bit map in R4 |
| rx_toolong | input | 1 | Received frame exceeded the maximum packet size |
| tx_evt | input | 1 | One-cycle pulse per transmitted frame |
| tx_len | input | LEN_W | Transmitted frame length in bytes |
| tx_flags | input | 4 | Transmit class flags, bit map in R5 |
| rx_fifo_empty | input | 1 | Live receive FIFO empty status |
| stat_clr | input | 1 | Clear all statistics |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 32 | Read data, valid one clock after rd_en |

## Verification
A counter that misses an event or counts one twice shows up at the next read of that counter, one clock after rd_en. A counter that clears too much or too little shows up at the read after that one. A wrong latch shows up only when the high byte word is read, so the tests move more than 2^32 bytes and hold the high read back until further traffic has arrived. A wrong priority between clearing and counting shows up in one cycle, because events are driven in the same clock as the clearing read or the stat_clr pulse.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
    localparam int N_HIST    = 7;
    localparam int N_RXF     = 8;
    localparam int N_TXF     = 4;
    localparam int RX_GEN    = 1 + N_RXF + N_HIST;
    localparam int TX_GEN    = 1 + N_TXF + N_HIST;
    localparam int N_GEN     = RX_GEN + TX_GEN;
    localparam int A_RXB_LO  = 0;
    localparam int A_RXB_HI  = 1;
    localparam int A_TXB_LO  = 2;
    localparam int A_TXB_HI  = 3;
    localparam int A_TOOLONG = 4;
    localparam int A_GEN     = 8;

    // one-hot length bin; all zero for runts
    function automatic logic [N_HIST-1:0] hist_bin(input logic [31:0] len);
        logic [N_HIST-1:0] b;
        b = '0;
        if (len == 32'd64)                         b[0] = 1'b1;
        else if (len > 32'd64   && len < 32'd128)  b[1] = 1'b1;
        else if (len >= 32'd128 && len < 32'd256)  b[2] = 1'b1;
        else if (len >= 32'd256 && len < 32'd512)  b[3] = 1'b1;
        else if (len >= 32'd512 && len < 32'd1024) b[4] = 1'b1;
        else if (len >= 32'd1024 && len < 32'd1519) b[5] = 1'b1;
        else if (len >= 32'd1519)                  b[6] = 1'b1;
        return b;
    endfunction
endpackage

// File: rtl/mstat_sat_cnt.sv
module mstat_sat_cnt #(
    parameter int W  = 32,
    parameter int IW = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc_en,
    input  logic [IW-1:0] inc_val,
    output logic [W-1:0]  cnt
);
    logic [W-1:0] cnt_d, cnt_q;
    logic [W-1:0] base;
    logic [W:0]   sum;

    always_comb begin
        base  = clr ? '0 : cnt_q;
        sum   = {1'b0, base} + {{(W + 1 - IW){1'b0}}, inc_val};
        cnt_d = base;
        if (inc_en) cnt_d = sum[W] ? {W{1'b1}} : sum[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/mstat_evt_map.sv
module mstat_evt_map
    import mstat_pkg::*;
#(
    parameter int NF    = 8,
    parameter int LEN_W = 14,
    localparam int NO   = 1 + NF + N_HIST
) (
    input  logic             evt,
    input  logic [LEN_W-1:0] len,
    input  logic [NF-1:0]    flags,
    output logic [NO-1:0]    inc
);
    logic [N_HIST-1:0] bin;

    always_comb begin
        bin    = hist_bin(32'(len));
        inc[0] = evt;
        for (int i = 0; i < NF; i++)     inc[1 + i]      = evt & flags[i];
        for (int b = 0; b < N_HIST; b++) inc[1 + NF + b] = evt & bin[b];
    end
endmodule

// File: rtl/mstat_top.sv
module mstat_top
    import mstat_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int BYTE_W = 45,
    parameter int LEN_W  = 14,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_evt,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [N_RXF-1:0]  rx_flags,
    input  logic              rx_toolong,
    input  logic              tx_evt,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic [N_TXF-1:0]  tx_flags,
    input  logic              rx_fifo_empty,
    input  logic              stat_clr,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data
);
    localparam int HI_W = BYTE_W - 32;
    localparam int TL_W = CNT_W - 1;

    typedef struct packed {
        logic [31:0]     rd_data;
        logic [HI_W-1:0] hi_rx;
        logic [HI_W-1:0] hi_tx;
    } rd_st_t;

    rd_st_t st_d, st_q;

    logic [RX_GEN-1:0] rx_inc;
    logic [TX_GEN-1:0] tx_inc;
    logic [N_GEN-1:0]  gen_inc, gen_clr;
    logic [CNT_W-1:0]  gen_cnt [N_GEN];
    logic [BYTE_W-1:0] byte_cnt [2];
    logic [1:0]        byte_clr, byte_evt;
    logic [LEN_W-1:0]  byte_len [2];
    logic [TL_W-1:0]   tl_cnt;
    logic              tl_clr;
    logic [31:0]       rd_val;

    mstat_evt_map #(.NF(N_RXF), .LEN_W(LEN_W)) rx_map_i (
        .evt(rx_evt), .len(rx_len), .flags(rx_flags), .inc(rx_inc));
    mstat_evt_map #(.NF(N_TXF), .LEN_W(LEN_W)) tx_map_i (
        .evt(tx_evt), .len(tx_len), .flags(tx_flags), .inc(tx_inc));

    assign gen_inc     = {tx_inc, rx_inc};
    assign byte_evt    = {tx_evt, rx_evt};
    assign byte_len[0] = rx_len;
    assign byte_len[1] = tx_len;

    always_comb begin
        for (int g = 0; g < N_GEN; g++)
            gen_clr[g] = stat_clr | (rd_en && rd_addr == ADDR_W'(A_GEN + g));
        byte_clr[0] = stat_clr | (rd_en && rd_addr == ADDR_W'(A_RXB_LO));
        byte_clr[1] = stat_clr | (rd_en && rd_addr == ADDR_W'(A_TXB_LO));
        tl_clr      = stat_clr | (rd_en && rd_addr == ADDR_W'(A_TOOLONG));
    end

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        mstat_sat_cnt #(.W(CNT_W), .IW(1)) cnt_i (
            .clk(clk), .rst_n(rst_n), .clr(gen_clr[g]), .inc_en(gen_inc[g]),
            .inc_val(1'b1), .cnt(gen_cnt[g]));
    end

    for (genvar d = 0; d < 2; d++) begin : g_byte
        mstat_sat_cnt #(.W(BYTE_W), .IW(LEN_W)) cnt_i (
            .clk(clk), .rst_n(rst_n), .clr(byte_clr[d]), .inc_en(byte_evt[d]),
            .inc_val(byte_len[d]), .cnt(byte_cnt[d]));
    end

    mstat_sat_cnt #(.W(TL_W), .IW(1)) tl_cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(tl_clr), .inc_en(rx_evt & rx_toolong),
        .inc_val(1'b1), .cnt(tl_cnt));

    always_comb begin
        rd_val = '0;
        if (rd_addr == ADDR_W'(A_RXB_LO)) rd_val = byte_cnt[0][31:0];
        if (rd_addr == ADDR_W'(A_RXB_HI)) rd_val = 32'(st_q.hi_rx);
        if (rd_addr == ADDR_W'(A_TXB_LO)) rd_val = byte_cnt[1][31:0];
        if (rd_addr == ADDR_W'(A_TXB_HI)) rd_val = 32'(st_q.hi_tx);
        if (rd_addr == ADDR_W'(A_TOOLONG)) rd_val = {rx_fifo_empty, 31'(tl_cnt)};
        for (int g = 0; g < N_GEN; g++)
            if (rd_addr == ADDR_W'(A_GEN + g)) rd_val = 32'(gen_cnt[g]);

        st_d = st_q;
        if (rd_en) begin
            st_d.rd_data = rd_val;
            if (rd_addr == ADDR_W'(A_RXB_LO)) st_d.hi_rx = byte_cnt[0][BYTE_W-1:32];
            if (rd_addr == ADDR_W'(A_TXB_LO)) st_d.hi_tx = byte_cnt[1][BYTE_W-1:32];
        end
        if (stat_clr) begin
            st_d.hi_rx = '0;
            st_d.hi_tx = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rd_data;
endmodule

// File: rtl/mstat_chk.sv
module mstat_chk #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data,
    input logic              rx_fifo_empty,
    input logic              stat_clr,
    input logic              rx_evt,
    input logic [CNT_W-1:0]  rxfrm
);
    logic rd_frm;
    assign rd_frm = rd_en && rd_addr == ADDR_W'(8);

    // R2
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R2
    rd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_frm |=> rd_data == 32'($past(rxfrm)));

    // R3
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_frm && !rx_evt) |=> rxfrm == '0);

    // R9
    fifo_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == ADDR_W'(4)) |=> rd_data[31] == $past(rx_fifo_empty));

    // R10
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr && !rx_evt) |=> rxfrm == '0);

    // R11
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxfrm == '1 && rx_evt && !stat_clr && !rd_frm) |=> rxfrm == '1);
endmodule

bind mstat_top mstat_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rx_fifo_empty(rx_fifo_empty), .stat_clr(stat_clr),
    .rx_evt(rx_evt), .rxfrm(gen_cnt[0]));

// File: tb/mstat_top_tb.sv
module mstat_top_tb_top;
    localparam int CNT_W  = 8;
    localparam int BYTE_W = 45;
    localparam int LEN_W  = 26;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_evt = 1'b0, rx_toolong = 1'b0;
    logic [LEN_W-1:0]  rx_len = '0, tx_len = '0;
    logic [7:0]        rx_flags = '0;
    logic              tx_evt = 1'b0;
    logic [3:0]        tx_flags = '0;
    logic              rx_fifo_empty = 1'b0, stat_clr = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    mstat_top #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_evt(rx_evt), .rx_len(rx_len),
        .rx_flags(rx_flags), .rx_toolong(rx_toolong), .tx_evt(tx_evt),
        .tx_len(tx_len), .tx_flags(tx_flags), .rx_fifo_empty(rx_fifo_empty),
        .stat_clr(stat_clr), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = ADDR_W'(a);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [63:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, 64'(d), exp);
    endtask

    task automatic rx_frame(input int len, input logic [7:0] fl, input logic tl);
        @(negedge clk);
        rx_evt = 1'b1; rx_len = LEN_W'(len); rx_flags = fl; rx_toolong = tl;
        @(negedge clk);
        rx_evt = 1'b0; rx_flags = '0; rx_toolong = 1'b0;
    endtask

    task automatic tx_frame(input int len, input logic [3:0] fl);
        @(negedge clk);
        tx_evt = 1'b1; tx_len = LEN_W'(len); tx_flags = fl;
        @(negedge clk);
        tx_evt = 1'b0; tx_flags = '0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 rd_data", 64'(rd_data), 0);
        rd_chk("R1 rx frames", 8'h08, 0);
        rd_chk("R1 rx bytes lo", 8'h00, 0);
        rd_chk("R1 rx bytes hi", 8'h01, 0);
        rd_chk("R1 too long", 8'h04, 0);
        rd_chk("R1 tx frames", 8'h18, 0);
    endtask

    task automatic t_rx_hist();
        int lens[9] = '{64, 100, 200, 300, 600, 1200, 1518, 1519, 40};
        int expb[7] = '{1, 1, 1, 1, 1, 2, 1};
        longint sum = 0;
        clear_all();
        foreach (lens[i]) begin
            rx_frame(lens[i], 8'h00, 1'b0);
            sum += lens[i];
        end
        rd_chk("R4 rx frames", 8'h08, 9);
        rd_chk("R7 rx bytes lo", 8'h00, 64'(sum));
        for (int b = 0; b < 7; b++) rd_chk("R6 rx bin", 8'h11 + b, 64'(expb[b]));
        rd_chk("R3 rx frames cleared", 8'h08, 0);
        rd_chk("R3 rx bin5 cleared", 8'h16, 0);
        rd_chk("R5 tx frames untouched", 8'h18, 0);
    endtask

    task automatic t_rx_flags();
        clear_all();
        for (int i = 0; i < 8; i++)
            for (int k = 0; k <= i; k++) rx_frame(64, 8'(1 << i), 1'b0);
        rx_frame(70, 8'hFF, 1'b0);
        for (int i = 0; i < 8; i++) rd_chk("R4 rx flag count", 8'h09 + i, 64'(i + 2));
        rd_chk("R4 rx frames", 8'h08, 37);
    endtask

    task automatic t_tx();
        clear_all();
        tx_frame(64, 4'b0001);
        tx_frame(1519, 4'b0110);
        tx_frame(70, 4'b1010);
        tx_frame(30, 4'b1000);
        rd_chk("R5 tx frames", 8'h18, 4);
        rd_chk("R5 tx mcast", 8'h19, 1);
        rd_chk("R5 tx bcast", 8'h1A, 2);
        rd_chk("R5 tx pause", 8'h1B, 1);
        rd_chk("R5 tx err", 8'h1C, 2);
        rd_chk("R7 tx bytes lo", 8'h02, 64 + 1519 + 70 + 30);
        rd_chk("R6 tx bin0", 8'h1D, 1);
        rd_chk("R6 tx bin1", 8'h1E, 1);
        rd_chk("R6 tx bin6", 8'h23, 1);
        rd_chk("R6 tx bin2", 8'h1F, 0);
        rd_chk("R5 rx frames untouched", 8'h08, 0);
    endtask

    task automatic t_bytes_hi();
        longint big = (64'd1 << LEN_W) - 1;
        longint tot;
        clear_all();
        for (int i = 0; i < 100; i++) rx_frame(int'(big), 8'h00, 1'b0);
        tot = big * 100;
        rd_chk("R7 rx bytes lo wide", 8'h00, tot & 64'hFFFF_FFFF);
        rx_frame(1000, 8'h00, 1'b0);
        rd_chk("R8 rx hi latched", 8'h01, tot >> 32);
        rd_chk("R8 rx hi read again", 8'h01, tot >> 32);
        rd_chk("R8 rx lo after clear", 8'h00, 1000);
        rd_chk("R8 rx hi after clear", 8'h01, 0);
        for (int i = 0; i < 70; i++) tx_frame(int'(big), 4'h0);
        tot = big * 70;
        rd_chk("R7 tx bytes lo wide", 8'h02, tot & 64'hFFFF_FFFF);
        rd_chk("R8 tx hi latched", 8'h03, tot >> 32);
    endtask

    task automatic t_same_cycle();
        logic [31:0] d;
        clear_all();
        for (int i = 0; i < 3; i++) rx_frame(64, 8'h00, 1'b0);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 6'h08;
        rx_evt = 1'b1; rx_len = LEN_W'(64);
        @(negedge clk);
        rd_en = 1'b0; rx_evt = 1'b0;
        d = rd_data;
        check("R3 read returns old count", 64'(d), 3);
        rd_chk("R3 same-cycle event kept", 8'h08, 1);
        rd_chk("R3 other counter not cleared", 8'h11, 4);
    endtask

    task automatic t_clear_all();
        rx_frame(700, 8'h01, 1'b1);
        tx_frame(300, 4'h1);
        @(negedge clk);
        stat_clr = 1'b1;
        rx_evt = 1'b1; rx_len = LEN_W'(500); rx_flags = 8'h00;
        @(negedge clk);
        stat_clr = 1'b0; rx_evt = 1'b0;
        rd_chk("R10 rx frames new period", 8'h08, 1);
        rd_chk("R10 rx bytes new period", 8'h00, 500);
        rd_chk("R10 rx bin3 new period", 8'h14, 1);
        rd_chk("R10 rx bin4 zeroed", 8'h15, 0);
        rd_chk("R10 rx mcast zeroed", 8'h09, 0);
        rd_chk("R10 tx frames zeroed", 8'h18, 0);
        rd_chk("R10 tx bytes zeroed", 8'h02, 0);
        rd_chk("R10 too long zeroed", 8'h04, 0);
    endtask

    task automatic t_toolong();
        clear_all();
        for (int i = 0; i < 5; i++) rx_frame(2000, 8'h00, 1'b1);
        rx_frame(2000, 8'h00, 1'b0);
        rx_fifo_empty = 1'b1;
        rd_chk("R9 too long with empty flag", 8'h04, 64'h8000_0005);
        rx_fifo_empty = 1'b0;
        rd_chk("R9 too long cleared", 8'h04, 0);
    endtask

    task automatic t_sat();
        clear_all();
        for (int i = 0; i < 300; i++) rx_frame(64, 8'h01, 1'b1);
        rd_chk("R11 rx frames saturate", 8'h08, 255);
        rd_chk("R11 rx mcast saturate", 8'h09, 255);
        rd_chk("R11 too long saturate", 8'h04, 127);
        rd_chk("R11 bytes keep adding", 8'h00, 300 * 64);
    endtask

    task automatic t_misc();
        logic [31:0] d;
        clear_all();
        rx_frame(64, 8'h00, 1'b0);
        rx_frame(64, 8'h00, 1'b0);
        rd(8'h08, d);
        check("R2 read value", 64'(d), 2);
        repeat (4) @(negedge clk);
        check("R2 rd_data holds", 64'(rd_data), 2);
        rd_chk("R2 unmapped address", 8'h3F, 0);
        rd_chk("R2 unmapped address 5", 8'h05, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_hist();
        t_rx_flags();
        t_tx();
        t_bytes_hi();
        t_same_cycle();
        t_clear_all();
        t_toolong();
        t_sat();
        t_misc();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule